// File: doc/BRIEF.md
# PC-relative push and branch sequencer

This block carries out three three-byte instructions of an 8-bit processor, all built on one calculation: a signed 16-bit displacement added to the address of the following instruction. The displacement is carried in the two operand bytes, low byte first. The first instruction, push-relative, writes that sum to the stack. The second, long branch, loads the sum into the program counter. The third, branch-to-subroutine, first pushes a return address and then loads the sum into the program counter. The return address is the following instruction's address minus one, because the return instruction increments what it pulls.

The fetch logic raises `start` for one cycle with the opcode, the instruction's own address and the two operand bytes. The sequencer latches them and, for the pushing instructions, writes two bytes through a byte-wide memory port. The stack sits in a fixed page and grows downward. The sequencer then raises `done` for one cycle, together with the program-counter value to load.

Top module: `pcrel_unit`

## Requirements
- R1: After reset, `sp` is 0xFF, and `busy`, `done`, `pc_load` and `mem_we` are all low.
- R2: The computed target is (instruction address + 3 + signed displacement) modulo 65536, where the displacement is {disp_hi, disp_lo}. Displacements 0x7FFF and 0x8000 reach +32767 and -32768 from the following instruction.
- R3: Opcode 0x62 (push-relative) pushes the target in two writes: first the high byte to address {0x01, sp}, then the low byte to {0x01, sp-1}. It then raises `done` with `pc_load` high and `pc_out` = instruction address + 3.
- R4: Opcode 0x82 (long branch) makes no memory write and leaves `sp` unchanged. It raises `done` with `pc_load` high and `pc_out` = target.
- R5: Opcode 0x63 (branch-to-subroutine) pushes instruction address + 2 (high byte first, as in R3) and then raises `done` with `pc_load` high and `pc_out` = target.
- R6: If `start` is sampled at clock edge E, the writes of a pushing instruction fall in the cycles after E+0 and E+1, and `done` follows after E+2. For the long branch, `done` follows directly after E.
- R7: Any other opcode gives a single `done` with `pc_load` low, no memory write and no change to `sp`.
- R8: `start` is ignored while `busy` is high. Results of the instruction in progress are unaffected, and no extra `done` follows.
- R9: Each written byte decrements `sp` by one. The decrement wraps from 0x00 to 0xFF, and the high address byte stays 0x01.
- R10: `done` lasts exactly one cycle, and `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Fetched opcode |
| instr_addr | input | 16 | Address of the opcode byte |
| disp_lo | input | 8 | First operand byte (displacement low) |
| disp_hi | input | 8 | Second operand byte (displacement high) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_load | output | 1 | Load `pc_out` into the program counter (with `done`) |
| pc_out | output | 16 | New program-counter value |
| sp | output | 8 | Stack pointer |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| mem_we | output | 1 | Stack write strobe |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any `start`. They also assume that `start` carries a defined opcode and operands whenever it is high. The stack-pointer step checks assume nothing else drives the stack between pushes. The bench changes inputs only on falling edges and holds reset for several cycles. It raises `start` during a busy sequence only in the deliberate R8 case, where the intruding opcode and operands differ from those in progress.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned INSN_LEN = 3;

  localparam logic [BYTE_W-1:0] OPC_PUSHREL = 8'h62;
  localparam logic [BYTE_W-1:0] OPC_BRLONG  = 8'h82;
  localparam logic [BYTE_W-1:0] OPC_CALLREL = 8'h63;

  typedef enum logic [1:0] {
    K_NONE,
    K_PUSH,
    K_BRANCH,
    K_CALL
  } op_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_FINISH
  } seq_state_t;

  function automatic op_kind_t decode_kind(input logic [BYTE_W-1:0] op);
    case (op)
      OPC_PUSHREL: return K_PUSH;
      OPC_BRLONG:  return K_BRANCH;
      OPC_CALLREL: return K_CALL;
      default:     return K_NONE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] after_insn(input logic [ADDR_W-1:0] pc);
    return ADDR_W'(pc + ADDR_W'(INSN_LEN));
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] pc,
                                                   input logic [BYTE_W-1:0] lo,
                                                   input logic [BYTE_W-1:0] hi);
    return ADDR_W'(after_insn(pc) + {hi, lo});
  endfunction

  function automatic logic [ADDR_W-1:0] call_return(input logic [ADDR_W-1:0] pc);
    return ADDR_W'(after_insn(pc) - ADDR_W'(1));
  endfunction

endpackage

// File: rtl/pcrel_addr.sv
module pcrel_addr
  import pcrel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] instr_addr,
  input  logic [BYTE_W-1:0] disp_lo,
  input  logic [BYTE_W-1:0] disp_hi,
  input  logic              push_sel,
  output logic [ADDR_W-1:0] target_q,
  output logic [ADDR_W-1:0] next_q,
  output logic [ADDR_W-1:0] push_val
);

  logic [ADDR_W-1:0] ret_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q <= '0;
      next_q   <= '0;
      ret_q    <= '0;
    end else if (capture) begin
      target_q <= rel_target(instr_addr, disp_lo, disp_hi);
      next_q   <= after_insn(instr_addr);
      ret_q    <= call_return(instr_addr);
    end
  end

  // push source: return address for the call, sum for push-relative
  assign push_val = push_sel ? ret_q : target_q;

  // R8
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(target_q) && $stable(next_q));

endmodule

// File: rtl/pcrel_stack.sv
module pcrel_stack
  import pcrel_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SP_RESET   = 8'hFF,
  parameter logic [BYTE_W-1:0] STACK_PAGE = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_hi,
  input  logic [ADDR_W-1:0] push_val,
  output logic [BYTE_W-1:0] sp,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we
);

  always_ff @(posedge clk) begin
    if (!rst_n) sp <= SP_RESET;
    else if (wr_en) sp <= BYTE_W'(sp - 1'b1);
  end

  assign mem_addr  = {STACK_PAGE, sp};
  assign mem_wdata = sel_hi ? push_val[ADDR_W-1:BYTE_W] : push_val[BYTE_W-1:0];
  assign mem_we    = wr_en;

  // R9
  sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sp == BYTE_W'($past(sp) - 8'd1));

  // R4
  sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sp));

  // R3
  hi_then_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_hi) |=> (wr_en && !sel_hi));

endmodule

// File: rtl/pcrel_ctrl.sv
module pcrel_ctrl
  import pcrel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] opcode,
  output logic              capture,
  output logic              busy,
  output logic              wr_en,
  output logic              sel_hi,
  output logic              push_sel,
  output logic              done,
  output logic              pc_load,
  output logic              pc_use_next
);

  seq_state_t state_q, state_d;
  op_kind_t   kind_q, kind_new;

  assign kind_new = decode_kind(opcode);
  assign capture  = start && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (capture)
                   state_d = (kind_new == K_PUSH || kind_new == K_CALL) ? ST_WR_HI : ST_FINISH;
      ST_WR_HI:  state_d = ST_WR_LO;
      ST_WR_LO:  state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_NONE;
    end else begin
      state_q <= state_d;
      if (capture) kind_q <= kind_new;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign wr_en       = (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
  assign sel_hi      = (state_q == ST_WR_HI);
  assign push_sel    = (kind_q == K_CALL);
  assign done        = (state_q == ST_FINISH);
  assign pc_load     = done && (kind_q != K_NONE);
  assign pc_use_next = (kind_q == K_PUSH);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R10
  we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R7
  load_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> done);

  // R6
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

endmodule

// File: rtl/pcrel_unit.sv
module pcrel_unit
  import pcrel_pkg::*;
#(
  parameter logic [7:0] SP_RESET   = 8'hFF,
  parameter logic [7:0] STACK_PAGE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [15:0] instr_addr,
  input  logic [7:0]  disp_lo,
  input  logic [7:0]  disp_hi,
  output logic        busy,
  output logic        done,
  output logic        pc_load,
  output logic [15:0] pc_out,
  output logic [7:0]  sp,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we
);

  logic              capture;
  logic              wr_en;
  logic              sel_hi;
  logic              push_sel;
  logic              pc_use_next;
  logic [ADDR_W-1:0] target_q;
  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] push_val;

  pcrel_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .opcode     (opcode),
    .capture    (capture),
    .busy       (busy),
    .wr_en      (wr_en),
    .sel_hi     (sel_hi),
    .push_sel   (push_sel),
    .done       (done),
    .pc_load    (pc_load),
    .pc_use_next(pc_use_next)
  );

  pcrel_addr u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .instr_addr(instr_addr),
    .disp_lo   (disp_lo),
    .disp_hi   (disp_hi),
    .push_sel  (push_sel),
    .target_q  (target_q),
    .next_q    (next_q),
    .push_val  (push_val)
  );

  pcrel_stack #(
    .SP_RESET  (SP_RESET),
    .STACK_PAGE(STACK_PAGE)
  ) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .sel_hi   (sel_hi),
    .push_val (push_val),
    .sp       (sp),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we)
  );

  assign pc_out = pc_use_next ? next_q : target_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (sp == SP_RESET) && !busy && !mem_we && !done);

  // R9
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_addr[15:8] == STACK_PAGE);

endmodule

// File: tb/test_pcrel_unit.sv
module test_pcrel_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] instr_addr = 16'h0000;
  logic [7:0]  disp_lo = 8'h00;
  logic [7:0]  disp_hi = 8'h00;
  logic        busy, done, pc_load, mem_we;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  sp, mem_wdata;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_sp = 8'hFF;

  always #5 clk = ~clk;

  pcrel_unit i_pcrel_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .instr_addr(instr_addr), .disp_lo(disp_lo), .disp_hi(disp_hi),
    .busy(busy), .done(done), .pc_load(pc_load), .pc_out(pc_out),
    .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  // {opcode, instr_addr, displacement, expected pc_out, expected pushed word}
  localparam int NV = 8;
  localparam logic [71:0] VECS [NV] = '{
    {8'h62, 16'h1000, 16'h0002, 16'h1003, 16'h1005},
    {8'h82, 16'h2000, 16'h7FFF, 16'hA002, 16'h0000},
    {8'h82, 16'h2000, 16'h8000, 16'hA003, 16'h0000},
    {8'h63, 16'h1234, 16'hFFF0, 16'h1227, 16'h1236},
    {8'h82, 16'hFFFE, 16'h0004, 16'h0005, 16'h0000},
    {8'h62, 16'h0000, 16'hFFFD, 16'h0003, 16'h0000},
    {8'h55, 16'h4000, 16'h1111, 16'h0000, 16'h0000},
    {8'h63, 16'hFFFD, 16'h0000, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drives one instruction and checks every cycle of it
  task automatic run_op(input logic [7:0] op, input logic [15:0] pc,
                        input logic [15:0] disp, input logic [15:0] exp_pc,
                        input logic [15:0] exp_push, input bit poke);
    bit pushes = (op == 8'h62) || (op == 8'h63);
    bit loads  = pushes || (op == 8'h82);
    string rq  = (op == 8'h62) ? "R3" : (op == 8'h63) ? "R5" :
                 (op == 8'h82) ? "R4" : "R7";
    @(negedge clk);
    start = 1'b1; opcode = op; instr_addr = pc;
    disp_lo = disp[7:0]; disp_hi = disp[15:8];
    @(negedge clk);
    if (poke) begin  // R8: second start while busy, different values
      start = 1'b1; opcode = 8'h82; instr_addr = 16'h5555;
      disp_lo = 8'h77; disp_hi = 8'h07;
    end else start = 1'b0;
    if (pushes) begin
      chk(mem_we == 1'b1, "R6", "write 1 strobe", 32'(mem_we), 32'd1);
      chk(mem_addr == {8'h01, exp_sp}, rq, "write 1 addr", 32'(mem_addr), {16'h0, 8'h01, exp_sp});
      chk(mem_wdata == exp_push[15:8], rq, "high byte", 32'(mem_wdata), 32'(exp_push[15:8]));
      chk(!done, "R6", "early done", 32'(done), 32'd0);
      exp_sp = 8'(exp_sp - 8'd1);
      @(negedge clk);
      start = 1'b0;
      chk(mem_we == 1'b1, "R6", "write 2 strobe", 32'(mem_we), 32'd1);
      chk(mem_addr == {8'h01, exp_sp}, "R9", "write 2 addr", 32'(mem_addr), {16'h0, 8'h01, exp_sp});
      chk(mem_wdata == exp_push[7:0], rq, "low byte", 32'(mem_wdata), 32'(exp_push[7:0]));
      exp_sp = 8'(exp_sp - 8'd1);
      @(negedge clk);
    end
    chk(done == 1'b1, "R6", "done", 32'(done), 32'd1);
    chk(mem_we == 1'b0, rq, "no write at done", 32'(mem_we), 32'd0);
    chk(pc_load == loads, rq, "pc_load", 32'(pc_load), 32'(loads));
    if (loads) chk(pc_out == exp_pc, "R2", "pc_out", 32'(pc_out), 32'(exp_pc));
    chk(sp == exp_sp, "R9", "sp", 32'(sp), 32'(exp_sp));
    @(negedge clk);
    chk(!done && !busy, "R10", "done pulse end", {30'h0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp == 8'hFF, "R1", "reset sp", 32'(sp), 32'hFF);
    chk(!busy && !done && !pc_load && !mem_we, "R1", "reset outputs",
        {28'h0, busy, done, pc_load, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sp == 8'hFF && !busy, "R1", "idle after reset", {23'h0, busy, sp}, 32'hFF);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i][71:64], VECS[i][63:48], VECS[i][47:32],
             VECS[i][31:16], VECS[i][15:0], 1'b0);

    // R8: start while busy is ignored
    run_op(8'h63, 16'h3000, 16'h0010, 16'h3013, 16'h3002, 1'b1);
    run_op(8'h62, 16'h0800, 16'h0100, 16'h0803, 16'h0903, 1'b1);

    // R9: many pushes wrap the stack pointer through 0x00
    for (int k = 0; k < 130; k++)
      run_op(8'h62, 16'(k * 7), 16'h0010, 16'(k * 7 + 3), 16'(k * 7 + 19), 1'b0);

    // R2: most negative displacement from low address wraps
    run_op(8'h82, 16'h0001, 16'h8000, 16'h8004, 16'h0000, 1'b0);

    // R1: reset mid-sequence restores the stack pointer
    @(negedge clk);
    start = 1'b1; opcode = 8'h62; instr_addr = 16'h1000; disp_lo = 8'h00; disp_hi = 8'h00;
    @(negedge clk);
    start = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(sp == 8'hFF && !busy && !mem_we, "R1", "reset mid-run",
        {22'h0, busy, mem_we, sp}, 32'hFF);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule